// File: doc/BRIEF.md
# Shared-Period Multichannel PWM Generator

This block drives up to a handful of pulse-width outputs from one common time base. The time base is an 8-bit tick counter, so every period is exactly 256 ticks long. An 8-bit prescaler sets how many input clock cycles make up one tick. The prescaler is therefore the only control over the period length. Each channel has its own 8-bit duty value. A single run bit gates every output at once.

Software reaches the block through a flat 32-bit register port: an address, write data, a write strobe, and combinational read data. The per-channel duty registers sit at word offsets starting from zero. The shared control word sits at offset 0x50. In that word the prescaler is split into two nibbles and the run bit sits between them.

Duty and prescaler writes made while the generator is running are held back. They take effect at the next period boundary, so no output ever sees a truncated or stretched pulse. Setting the run bit restarts the time base from zero.

Top module: `shared_pwm_top`

## Requirements
- R1: With prescaler value P, one tick lasts P+1 clock cycles. A period lasts 256 ticks, which is 256*(P+1) cycles.
- R2: The prescaler is written through the control word at byte offset 0x50. P[3:0] comes from bits 3:0 and P[7:4] comes from bits 14:11.
- R3: Channel n's duty register sits at byte offset 4*n. Its value V (bits 7:0) makes the output high from tick 0 through tick V, that is V+1 ticks, and low for the rest of the period.
- R4: A duty value of 255 keeps the output high for the whole period. A duty value of 0 gives a single-tick pulse.
- R5: Bit 9 of the control word is the shared run bit. In the cycle after a write that clears it, every output is low, and every output stays low while it is clear.
- R6: When the run bit is set after being clear, the first period starts from tick 0 and prescale count 0. All outputs go high in the second cycle after the write edge.
- R7: Duty or prescaler writes made while running take effect only at the next period boundary.
- R8: Reading the control word returns the prescaler nibbles and the run bit in their write positions, with every other bit zero. A duty read returns the value in bits 7:0, with zeros above. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH (4) | One pulse output per channel |

## Verification
The bench builds the block with its defaults: four channels, 8-bit duty values and an 8-bit split prescaler. With four channels, every duty slot is reachable, along with the gap between the last slot and the control word. Random runs use small prescaler values, so many whole periods fit in the cycle budget. A directed run uses a prescaler with both nibbles nonzero, which exercises the split field. Another directed run changes the duty and the prescaler in mid-period and checks the output cycle by cycle across the boundary.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
   localparam int unsigned CTRL_OFS   = 32'h50;
   localparam int unsigned PS_LO_LSB  = 0;
   localparam int unsigned PS_HI_LSB  = 11;
   localparam int unsigned RUN_BIT    = 9;
   localparam int unsigned NIB_W      = 4;
   localparam int unsigned DUTY_STRIDE = 4;

   function automatic logic [31:0] ctrl_image(input logic [2*NIB_W-1:0] ps, input logic run);
      logic [31:0] w;
      w = '0;
      w[PS_LO_LSB +: NIB_W] = ps[NIB_W-1:0];
      w[PS_HI_LSB +: NIB_W] = ps[2*NIB_W-1:NIB_W];
      w[RUN_BIT]            = run;
      return w;
   endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwmgen_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned PS_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic                         bus_we,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         run_reg,
   output logic [PS_W-1:0]              ps_reg,
   output logic [NUM_CH-1:0][DUTY_W-1:0] duty_reg
);
   localparam int unsigned WA_W     = ADDR_W - 2;
   localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_OFS / 4);

   logic [WA_W-1:0] word_addr;
   logic            ctrl_hit;
   logic [NUM_CH-1:0] duty_hit;

   assign word_addr = bus_addr[ADDR_W-1:2];
   assign ctrl_hit  = (word_addr == CTRL_WA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_reg <= 1'b0;
         ps_reg  <= '0;
      end else if (bus_we && ctrl_hit) begin
         run_reg <= bus_wdata[RUN_BIT];
         ps_reg  <= {bus_wdata[PS_HI_LSB +: NIB_W], bus_wdata[PS_LO_LSB +: NIB_W]};
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_duty
      assign duty_hit[n] = (word_addr == WA_W'(n * DUTY_STRIDE / 4));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_reg[n] <= '0;
         else if (bus_we && duty_hit[n])
            duty_reg[n] <= bus_wdata[DUTY_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_hit)
         bus_rdata = DATA_W'(ctrl_image(ps_reg, run_reg));
      for (int i = 0; i < NUM_CH; i++) begin
         if (duty_hit[i])
            bus_rdata = DATA_W'(duty_reg[i]);
      end
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PS_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_reg,
   input  logic [PS_W-1:0]  ps_reg,
   output logic             run_q,
   output logic             running,
   output logic             period_end,
   output logic             load_now,
   output logic [PS_W-1:0]  act_ps,
   output logic [PS_W-1:0]  ps_cnt,
   output logic [CNT_W-1:0] tick_cnt
);
   localparam logic [CNT_W-1:0] TICK_LAST = {CNT_W{1'b1}};

   logic tick_end;

   assign running    = run_reg && run_q;
   assign tick_end   = running && (ps_cnt == act_ps);
   assign period_end = tick_end && (tick_cnt == TICK_LAST);
   assign load_now   = !run_q || period_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else
         run_q <= run_reg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_ps <= '0;
      else if (load_now)
         act_ps <= ps_reg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_cnt   <= '0;
         tick_cnt <= '0;
      end else if (!running) begin
         ps_cnt   <= '0;
         tick_cnt <= '0;
      end else if (tick_end) begin
         ps_cnt   <= '0;
         tick_cnt <= tick_cnt + 1'b1;
      end else begin
         ps_cnt   <= ps_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int unsigned CNT_W = 8,
   parameter bit          HOLD_TO_BOUNDARY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_now,
   input  logic             running,
   input  logic [CNT_W-1:0] duty_reg,
   input  logic [CNT_W-1:0] tick_cnt,
   output logic             pwm_o
);
   logic [CNT_W-1:0] act_duty;

   if (HOLD_TO_BOUNDARY) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_duty <= '0;
         else if (load_now)
            act_duty <= duty_reg;
      end
   end else begin : g_direct
      assign act_duty = duty_reg;
   end

   assign pwm_o = running && (tick_cnt <= act_duty);
endmodule

// File: rtl/shared_pwm_top.sv
module shared_pwm_top
   import pwmgen_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PS_W   = 8,
   parameter bit          HOLD_TO_BOUNDARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1 || NUM_CH * DUTY_STRIDE > CTRL_OFS) begin : g_bad_ch
      $error("NUM_CH must be at least 1 and keep duty slots below the control word");
   end
   if (PS_W != 2 * NIB_W) begin : g_bad_ps
      $error("PS_W must equal two prescaler nibbles");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must fit in the data word");
   end
   if (ADDR_W < 8 || DATA_W < 16) begin : g_bad_bus
      $error("bus must reach the control word and hold its fields");
   end

   logic                         run_reg;
   logic [PS_W-1:0]              ps_reg;
   logic [NUM_CH-1:0][CNT_W-1:0] duty_reg;
   logic                         run_q;
   logic                         running;
   logic                         period_end;
   logic                         load_now;
   logic [PS_W-1:0]              act_ps;
   logic [PS_W-1:0]              ps_cnt;
   logic [CNT_W-1:0]             tick_cnt;

   pwm_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUTY_W(CNT_W), .PS_W(PS_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .run_reg(run_reg), .ps_reg(ps_reg),
      .duty_reg(duty_reg)
   );

   pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run_reg(run_reg), .ps_reg(ps_reg), .run_q(run_q),
      .running(running), .period_end(period_end), .load_now(load_now),
      .act_ps(act_ps), .ps_cnt(ps_cnt), .tick_cnt(tick_cnt)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W), .HOLD_TO_BOUNDARY(HOLD_TO_BOUNDARY)) u_ch (
         .clk(clk), .rst_n(rst_n), .load_now(load_now), .running(running),
         .duty_reg(duty_reg[n]), .tick_cnt(tick_cnt), .pwm_o(pwm_out[n])
      );
   end
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk
   import pwmgen_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PS_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [NUM_CH-1:0] pwm_out,
   input logic              run_q,
   input logic              running,
   input logic              period_end,
   input logic [PS_W-1:0]   act_ps,
   input logic [PS_W-1:0]   ps_cnt,
   input logic [CNT_W-1:0]  tick_cnt
);
   logic ctrl_off_wr;
   assign ctrl_off_wr = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(CTRL_OFS / 4))
                        && !bus_wdata[RUN_BIT];

   assert_tick_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ps_cnt <= act_ps);

   assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (running && ps_cnt != act_ps) |=> $stable(tick_cnt));

   assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_cnt == '0) |-> (pwm_out == {NUM_CH{1'b1}}));

   assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_off_wr |=> (pwm_out == '0));

   assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> (tick_cnt == '0 && ps_cnt == '0));

   assert_ps_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !period_end) |=> $stable(act_ps));
endmodule

bind shared_pwm_top pwm_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .pwm_out(pwm_out), .run_q(run_q), .running(running),
   .period_end(period_end), .act_ps(act_ps), .ps_cnt(ps_cnt), .tick_cnt(tick_cnt)
);

// File: tb/tb_shared_pwm_top.sv
module tb_shared_pwm_top;
   import pwmgen_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   shared_pwm_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit model_out(input int cyc, input int p, input int duty);
      int tick;
      tick = cyc / (p + 1);
      return (tick <= duty);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic run_check(input int p, input logic [NCH-1:0][7:0] duty, input string req);
      int miss [NCH];
      for (int n = 0; n < NCH; n++) begin
         miss[n] = 0;
         wr(8'(4 * n), {24'h0, duty[n]});
      end
      wr(8'(CTRL_OFS), ctrl_image(8'(p), 1'b1));
      for (int c = 0; c < 256 * (p + 1); c++) begin
         @(negedge clk);
         for (int n = 0; n < NCH; n++)
            if (pwm_out[n] !== model_out(c, p, duty[n])) miss[n]++;
      end
      for (int n = 0; n < NCH; n++)
         chk(miss[n] == 0, req, miss[n], 0);
      wr(8'(CTRL_OFS), ctrl_image(8'(p), 1'b0));
      chk(pwm_out == '0, "R5 outputs low after clear", pwm_out, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      logic [NCH-1:0][7:0] dv;
      int p;
      int miss;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      chk(pwm_out == '0, "R5 reset outputs low", pwm_out, 0);
      rst_n = 1'b1;
      rd(8'h50, rv);
      chk(rv == 0, "R8 reset ctrl reads zero", rv, 0);

      // R8 readback of fields and masking
      wr(8'h50, 32'hFFFF_FFFF);
      rd(8'h50, rv);
      chk(rv == 32'h0000_7A0F, "R8 ctrl readback", rv, 32'h7A0F);
      wr(8'h50, 32'h0);
      wr(8'h08, 32'hABCD_EF5A);
      rd(8'h08, rv);
      chk(rv == 32'h5A, "R8 duty readback", rv, 32'h5A);
      rd(8'h40, rv);
      chk(rv == 0, "R8 unmapped reads zero", rv, 0);

      // R3 R4 extremes: 0, 255, mid values
      dv = {8'd255, 8'd0, 8'd127, 8'd254};
      run_check(0, dv, "R4 duty extremes P=0");
      dv = {8'd1, 8'd64, 8'd200, 8'd255};
      run_check(1, dv, "R3 duty pulse P=1");

      // R2 split prescaler, both nibbles nonzero: P=0x12
      dv = {8'd9, 8'd30, 8'd0, 8'd128};
      run_check(8'h12, dv, "R2 R1 split prescaler P=0x12");

      // R6 restart mid-period
      wr(8'h00, 32'd10);
      wr(8'h50, ctrl_image(8'd2, 1'b1));
      repeat (37) @(negedge clk);
      wr(8'h50, ctrl_image(8'd2, 1'b0));
      dv = {8'd3, 8'd90, 8'd17, 8'd10};
      run_check(2, dv, "R6 restart from tick zero");

      // random trials
      for (int t = 0; t < 6; t++) begin
         p = int'($urandom % 4);
         for (int n = 0; n < NCH; n++) dv[n] = 8'($urandom);
         if (t == 2) dv[0] = 8'd0;
         if (t == 3) dv[1] = 8'd255;
         run_check(p, dv, "R1 R3 random period/duty");
      end

      // R7 mid-period changes wait for the boundary
      dv = {8'd100, 8'd100, 8'd100, 8'd40};
      for (int n = 0; n < NCH; n++) wr(8'(4 * n), {24'h0, dv[n]});
      wr(8'h50, ctrl_image(8'd1, 1'b1));
      miss = 0;
      for (int c = 0; c < 512 + 768; c++) begin
         @(negedge clk);
         for (int n = 0; n < NCH; n++) begin
            bit e;
            if (c < 512) e = model_out(c, 1, dv[n]);
            else e = model_out(c - 512, 2, (n == 0) ? 200 : dv[n]);
            if (pwm_out[n] !== e) miss++;
         end
         if (c == 200) begin
            bus_addr = 8'h00; bus_wdata = 32'd200; bus_we = 1'b1;
         end else if (c == 210) begin
            bus_addr = 8'h50; bus_wdata = ctrl_image(8'd2, 1'b1); bus_we = 1'b1;
         end else begin
            bus_we = 1'b0;
         end
      end
      chk(miss == 0, "R7 changes held to boundary", miss, 0);
      wr(8'h50, ctrl_image(8'd2, 1'b0));
      chk(pwm_out == '0, "R5 low after clear with duty 200", pwm_out, 0);
      repeat (20) @(negedge clk);
      chk(pwm_out == '0, "R5 stays low while clear", pwm_out, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule